// File: doc/BRIEF.md
# SPI Master Peripheral with Register Control

This block is a byte-wide SPI master that a small processor drives through three registers on a plain synchronous register bus. A control register holds the port enable, the SCK idle level, a four-bit rate field and a sticky collision flag. A data register accepts the byte to send and returns the byte received. A status register reports whether a transfer is running and whether a received byte is waiting. When software writes the data register, the block runs one full-duplex 8-bit exchange on SCK, SDO and SDI.

The rate field picks the SCK source. Three encodings divide the system clock, and one encoding follows an external timer pulse, with SCK toggling once per pulse. Every other encoding is treated as reserved: the master stays idle and SCK does not move. When the port is disabled, the block drives SCK and SDO low and lowers a pin-ownership output, so that surrounding logic can return the pins to general-purpose use.

Top module: `spi_host_ctrl`

## Requirements
- R1: A rate field of 0 gives an SCK period of 4 system clocks, 1 gives 16 and 2 gives 64. From the clock edge that accepts the data write to the clock edge that raises `done_o`, 8 SCK periods elapse.
- R2: A rate field of 3 makes SCK change level once for each cycle in which `timer_tick` is high. The transfer ends on the 16th such tick and not earlier.
- R3: Control bit 3 sets the SCK idle level (1 = high, 0 = low). While the port is enabled and no transfer is running, `sck_o` equals that bit.
- R4: Data moves MSB first. SDO changes on the SCK edge that leaves the idle level, and SDI is sampled on the edge that returns to it. After the transfer, the byte received on SDI is read back from the data register (address 1).
- R5: A transfer starts only when software writes the data register. Control writes, register reads and status reads produce no SCK activity.
- R6: A data write that arrives while a transfer is running sets the collision flag (control bit 1). That write is discarded, and the byte on SDO is unchanged.
- R7: The collision flag stays set when a control write carries a 1 in bit 1. It is cleared only by a control write that carries a 0 in bit 1.
- R8: The overflow indicator (control bit 0) always reads 0, even when received bytes are never read.
- R9: When control bit 2 (enable) is 0, `pins_en_o` is 0, `sck_o` and `sdo_o` are 0, and a data write starts nothing.
- R10: At the end of a transfer, `done_o` is high for exactly one cycle, the busy status bit (status bit 0, address 2) clears, and the buffer-full status bit (status bit 1) sets. A read of the data register clears buffer-full.
- R11: With a rate field of 4 to 15, a data write starts no transfer and SCK stays at its idle level.
- R12: The control register layout is rate in bits 7:4, idle level in bit 3, enable in bit 2, collision in bit 1 and overflow in bit 0. Reads are registered: `bus_rdata` is valid in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| timer_tick | input | 1 | External timer pulse, used as the SCK source when the rate field is 3 |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| pins_en_o | output | 1 | High while the port owns its pins |
| done_o | output | 1 | One-cycle pulse when a transfer ends |

## Verification
The bench measures the time from the write to `done_o` for each divider rate, and it steps the timer mode one tick at a time. These checks catch a design that uses the wrong half-period or ends the exchange one edge early. A slave model in the bench shifts a known byte back on SDI while it collects SDO on leading edges, so a design with reversed bit order or sampling on the wrong edge reads back a corrupted byte. The bench writes the data register again during a transfer to test collision handling: a design that loads the late byte corrupts SDO, and a design that clears the flag on any control write loses it. The bench also holds the port disabled and sets reserved rate fields, so a design that starts a transfer regardless toggles SCK when it should stay still.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  typedef enum logic [1:0] {
    RATE_DIV4   = 2'd0,
    RATE_DIV16  = 2'd1,
    RATE_DIV64  = 2'd2,
    RATE_TIMER  = 2'd3
  } rate_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // control register bit positions
  localparam int CTL_OVR  = 0;
  localparam int CTL_COLL = 1;
  localparam int CTL_EN   = 2;
  localparam int CTL_IDLE = 3;
  localparam int CTL_RATE = 4;

  function automatic logic rate_is_master(input logic [3:0] rate);
    return rate[3:2] == 2'b00;
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_host_pkg::*;
#(
  parameter int HALF_A = 2,
  parameter int HALF_B = 8,
  parameter int HALF_C = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  rate_e sel,
  input  logic  ext_tick,
  output logic  tick
);
  localparam int CW = $clog2(HALF_C + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      RATE_DIV4:  limit = CW'(HALF_A - 1);
      RATE_DIV16: limit = CW'(HALF_B - 1);
      RATE_DIV64: limit = CW'(HALF_C - 1);
      default:    limit = '0;
    endcase
  end

  assign tick = run && ((sel == RATE_TIMER) ? ext_tick : (cnt == limit));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (sel != RATE_TIMER) begin
      cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         halt,
  input  logic         start,
  input  logic [W-1:0] load_byte,
  input  logic         tick,
  input  logic         sdi,
  output logic         phase,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic [W-1:0]  tx_sh;
  logic [W-1:0]  rx_sh;
  logic [EW-1:0] edge_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      edge_cnt <= '0;
      phase    <= 1'b0;
      sdo      <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (halt) begin
        busy  <= 1'b0;
        phase <= 1'b0;
        sdo   <= 1'b0;
      end else if (start && !busy) begin
        busy     <= 1'b1;
        tx_sh    <= load_byte;
        edge_cnt <= '0;
        phase    <= 1'b0;
      end else if (busy && tick) begin
        phase <= ~phase;
        if (!edge_cnt[0]) begin
          sdo   <= tx_sh[W-1];
          tx_sh <= {tx_sh[W-2:0], 1'b0};
        end else begin
          rx_sh <= {rx_sh[W-2:0], sdi};
        end
        if (edge_cnt == LAST_EDGE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  assign rx_byte = rx_sh;

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       busy,
  input  logic       xfer_done,
  input  logic [7:0] rx_byte,
  output logic [3:0] rate,
  output logic       idle_high,
  output logic       enable,
  output logic       coll,
  output logic       data_wr,
  output logic       coll_clr,
  output logic       start
);
  logic       ctrl_wr;
  logic       rx_full;
  logic [7:0] rx_buf;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
  assign data_wr  = bus_wr && (bus_addr == ADDR_DATA);
  assign coll_clr = ctrl_wr && !bus_wdata[CTL_COLL];
  assign start    = data_wr && enable && rate_is_master(rate) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate      <= '0;
      idle_high <= 1'b0;
      enable    <= 1'b0;
      coll      <= 1'b0;
    end else if (ctrl_wr) begin
      rate      <= bus_wdata[CTL_RATE +: 4];
      idle_high <= bus_wdata[CTL_IDLE];
      enable    <= bus_wdata[CTL_EN];
      if (!bus_wdata[CTL_COLL]) coll <= 1'b0;
    end else if (data_wr && busy) begin
      coll <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
    end else if (xfer_done) begin
      rx_buf  <= rx_byte;
      rx_full <= 1'b1;
    end else if (bus_rd && bus_addr == ADDR_DATA) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_CTRL: bus_rdata <= {rate, idle_high, enable, coll, 1'b0};
        ADDR_DATA: bus_rdata <= rx_buf;
        ADDR_STAT: bus_rdata <= {6'b0, rx_full, busy};
        default:   bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       timer_tick,
  input  logic       sdi_i,
  output logic       sck_o,
  output logic       sdo_o,
  output logic       pins_en_o,
  output logic       done_o
);
  localparam int BYTE_W = 8;

  logic [3:0]        rate;
  logic              idle_high;
  logic              enable;
  logic              coll;
  logic              data_wr;
  logic              coll_clr;
  logic              start;
  logic              busy;
  logic              tick;
  logic              phase;
  logic              sdo_raw;
  logic              mode_ok;
  logic [BYTE_W-1:0] rx_byte;

  assign mode_ok = rate_is_master(rate);

  spi_host_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .xfer_done (done_o),
    .rx_byte   (rx_byte),
    .rate      (rate),
    .idle_high (idle_high),
    .enable    (enable),
    .coll      (coll),
    .data_wr   (data_wr),
    .coll_clr  (coll_clr),
    .start     (start)
  );

  spi_rate_gen #(
    .HALF_A (DIV_FAST / 2),
    .HALF_B (DIV_MID / 2),
    .HALF_C (DIV_SLOW / 2)
  ) u_rate (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .sel      (rate_e'(rate[1:0])),
    .ext_tick (timer_tick),
    .tick     (tick)
  );

  spi_shift_core #(.W(BYTE_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .halt      (!enable),
    .start     (start),
    .load_byte (bus_wdata),
    .tick      (tick),
    .sdi       (sdi_i),
    .phase     (phase),
    .sdo       (sdo_raw),
    .busy      (busy),
    .done      (done_o),
    .rx_byte   (rx_byte)
  );

  assign pins_en_o = enable;
  assign sck_o     = enable & (idle_high ^ phase);
  assign sdo_o     = enable & sdo_raw;

endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic idle_high,
  input logic busy,
  input logic done,
  input logic sck,
  input logic sdo,
  input logic pins_en,
  input logic coll,
  input logic data_wr,
  input logic coll_clr,
  input logic mode_ok
);
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (enable && !busy) |-> (sck == idle_high)); // R3
  AST_START_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(data_wr && enable && mode_ok)); // R5
  AST_COLL_SET_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(coll) |-> $past(data_wr && busy)); // R6
  AST_COLL_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(coll) |-> $past(coll_clr)); // R7
  AST_OFF_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
    !pins_en |-> (!sck && !sdo)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !mode_ok) |=> !busy); // R11
endmodule

bind spi_host_ctrl spi_host_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .idle_high (idle_high),
  .busy      (busy),
  .done      (done_o),
  .sck       (sck_o),
  .sdo       (sdo_o),
  .pins_en   (pins_en_o),
  .coll      (coll),
  .data_wr   (data_wr),
  .coll_clr  (coll_clr),
  .mode_ok   (mode_ok)
);

// File: tb/spi_host_ctrl_test.sv
module spi_host_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       timer_tick = 1'b0;
  logic       sdi_i = 1'b0;
  logic       sck_o, sdo_o, pins_en_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // slave model state
  logic       mon_on = 1'b0;
  logic       idle_lvl = 1'b0;
  logic       prev_sck = 1'b0;
  logic [7:0] slave_byte = '0;
  logic [7:0] mosi_cap = '0;
  int         lead_cnt = 0;
  int         sck_moves = 0;
  int         done_cnt = 0;

  spi_host_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_tick(timer_tick), .sdi_i(sdi_i), .sck_o(sck_o), .sdo_o(sdo_o),
    .pins_en_o(pins_en_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sck_o != prev_sck) sck_moves <= sck_moves + 1;
    if (done_o) done_cnt <= done_cnt + 1;
    if (mon_on && sck_o != prev_sck && sck_o != idle_lvl) begin
      mosi_cap <= {mosi_cap[6:0], sdo_o};
      sdi_i    <= slave_byte[7 - (lead_cnt % 8)];
      lead_cnt <= lead_cnt + 1;
    end
    prev_sck <= sck_o;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] ctl(input logic [3:0] rate, input logic idle,
                                     input logic en, input logic keep);
    return {rate, idle, en, keep, 1'b0};
  endfunction

  task automatic arm_monitor(input logic idle, input logic [7:0] sbyte);
    @(negedge clk);
    idle_lvl = idle; slave_byte = sbyte; lead_cnt = 0; mosi_cap = '0;
    mon_on = 1'b1;
  endtask

  task automatic wait_done(input int limit, output int waited);
    waited = 0;
    while (!done_o && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  // divider modes: timing, data both ways, status
  task automatic t_divider(input logic [3:0] rate, input int period,
                           input logic idle, input logic [7:0] tx,
                           input logic [7:0] sb);
    logic [7:0] d;
    int c0, w;
    wr(2'd0, ctl(rate, idle, 1'b1, 1'b1));
    arm_monitor(idle, sb);
    check("R3 idle level", int'(sck_o), int'(idle));
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = tx;
    @(posedge clk); #1 c0 = cyc;
    @(negedge clk); bus_wr = 1'b0;
    wait_done(8 * period + 50, w);
    check("R1 transfer length", cyc - c0, 8 * period);
    @(negedge clk);
    mon_on = 1'b0;
    check("R4 SDO byte msb first", int'(mosi_cap), int'(tx));
    check("R4 SDO leading edges", lead_cnt, 8);
    check("R3 idle after transfer", int'(sck_o), int'(idle));
    rd(2'd2, d);
    check("R10 full set, busy clear", int'(d[1:0]), 2);
    rd(2'd1, d);
    check("R4 received byte", int'(d), int'(sb));
    rd(2'd2, d);
    check("R10 full cleared by read", int'(d[1]), 0);
  endtask

  task automatic t_timer_mode();
    int d0;
    logic [7:0] d;
    wr(2'd0, ctl(4'd3, 1'b0, 1'b1, 1'b1));
    arm_monitor(1'b0, 8'h96);
    wr(2'd1, 8'h4B);
    repeat (20) @(negedge clk);
    check("R2 no SCK without ticks", int'(sck_o), 0);
    d0 = done_cnt;
    for (int i = 0; i < 16; i++) begin
      if (i == 15) check("R2 not done before 16th tick", done_cnt - d0, 0);
      @(negedge clk); timer_tick = 1'b1;
      @(negedge clk); timer_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
    check("R2 done after 16 ticks", done_cnt - d0, 1);
    mon_on = 1'b0;
    check("R2 SDO byte", int'(mosi_cap), 8'h4B);
    rd(2'd1, d);
    check("R2 received byte", int'(d), 8'h96);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    int w;
    wr(2'd0, ctl(4'd1, 1'b0, 1'b1, 1'b1));
    arm_monitor(1'b0, 8'h00);
    wr(2'd1, 8'hA5);
    repeat (30) @(negedge clk);
    wr(2'd1, 8'h3C);
    wait_done(400, w);
    @(negedge clk);
    mon_on = 1'b0;
    check("R6 first byte kept", int'(mosi_cap), 8'hA5);
    rd(2'd0, d);
    check("R6 collision flag set", int'(d[1]), 1);
    repeat (100) @(negedge clk);
    rd(2'd2, d);
    check("R6 discarded write started nothing", int'(d[0]), 0);
    wr(2'd0, ctl(4'd1, 1'b0, 1'b1, 1'b1));
    rd(2'd0, d);
    check("R7 flag kept by write of 1", int'(d[1]), 1);
    wr(2'd0, ctl(4'd1, 1'b0, 1'b1, 1'b0));
    rd(2'd0, d);
    check("R7 flag cleared by write of 0", int'(d[1]), 0);
  endtask

  task automatic t_no_overflow();
    logic [7:0] d;
    int w;
    wr(2'd0, ctl(4'd0, 1'b0, 1'b1, 1'b1));
    for (int i = 0; i < 3; i++) begin
      wr(2'd1, 8'h11);
      wait_done(100, w);
    end
    rd(2'd0, d);
    check("R8 overflow bit stays 0", int'(d[0]), 0);
    check("R12 control layout", int'(d), int'(ctl(4'd0, 1'b0, 1'b1, 1'b0)));
    rd(2'd1, d);
  endtask

  task automatic t_no_spurious_start();
    logic [7:0] d;
    int m0;
    wr(2'd0, ctl(4'd0, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    m0 = sck_moves;
    rd(2'd0, d);
    rd(2'd2, d);
    rd(2'd1, d);
    wr(2'd0, ctl(4'd0, 1'b1, 1'b1, 1'b1));
    wr(2'd2, 8'hFF);
    repeat (20) @(negedge clk);
    check("R5 no SCK without data write", sck_moves - m0, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    int m0, d0;
    wr(2'd0, ctl(4'd0, 1'b1, 1'b0, 1'b1));
    @(negedge clk);
    check("R9 pins released", int'(pins_en_o), 0);
    check("R9 SCK low", int'(sck_o), 0);
    m0 = sck_moves; d0 = done_cnt;
    wr(2'd1, 8'hFF);
    repeat (60) @(negedge clk);
    check("R9 no SCK when disabled", sck_moves - m0, 0);
    check("R9 SDO low", int'(sdo_o), 0);
    check("R9 no done when disabled", done_cnt - d0, 0);
    rd(2'd2, d);
    check("R9 not busy", int'(d[0]), 0);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    int m0, d0;
    for (int r = 4; r < 16; r += 5) begin
      wr(2'd0, ctl(4'(r), 1'b0, 1'b1, 1'b1));
      repeat (2) @(negedge clk);
      m0 = sck_moves; d0 = done_cnt;
      wr(2'd1, 8'hC3);
      repeat (150) @(negedge clk);
      check("R11 no SCK in reserved rate", sck_moves - m0, 0);
      check("R11 no done in reserved rate", done_cnt - d0, 0);
      rd(2'd2, d);
      check("R11 not busy", int'(d[0]), 0);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 reset pins released", int'(pins_en_o), 0);
    check("R10 reset no done", int'(done_o), 0);
    rd(2'd0, d);
    check("R12 reset control", int'(d), 0);
    rd(2'd2, d);
    check("R10 reset status", int'(d), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_divider(4'd0, 4,  1'b0, 8'hA6, 8'h5D);
    t_divider(4'd1, 16, 1'b0, 8'h81, 8'h7E);
    t_divider(4'd2, 64, 1'b1, 8'h3C, 8'hC1);
    t_divider(4'd0, 4,  1'b1, 8'hFF, 8'h00);
    t_timer_mode();
    t_collision();
    t_no_overflow();
    t_no_spurious_start();
    t_disabled();
    t_reserved();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule